// File: doc/BRIEF.md
# Parallel-Chain Debiasing Conditioner with Folding Word Buffer

This block takes raw samples from several parallel noise chains and reduces them to one bit per sample by XOR. A pairwise extractor then removes bias. Samples are grouped into consecutive, non-overlapping pairs. A pair of equal bits is dropped. A pair of unequal bits yields one output bit. Because pairs are rejected depending on the data, accepted bits come out at a variable rate.

Accepted bits are folded into a 16-bit word buffer. Each new bit causes a one-position left rotation of the buffer, and the new bit is XORed into bit 0. When sixteen bits have been folded in since the last wipe, the word is marked ready. While the word waits for a consumer, the buffer keeps absorbing new bits in the same way. A read strobe takes the word and wipes the buffer. The output shows zero whenever the word is not complete.

Top module: `entropy_fold_conditioner`

## Requirements
- R1: On each sample, `raw_bits[i]` is the bit from chain i. The sample bit is the XOR of all `NCHAIN` chain bits.
- R2: Samples are taken only in cycles where `raw_valid` is 1. They are grouped into non-overlapping pairs (first, second) in arrival order. The pair (1,0) yields an accepted bit of 1 and the pair (0,1) yields 0, so the accepted bit equals the first sample bit.
- R3: Pairs (0,0) and (1,1) produce no accepted bit and leave the buffer unchanged.
- R4: On the clock edge where a bit is accepted, the buffer becomes its left rotation by one position with the new bit XORed into bit 0.
- R5: `word_ready` rises on the edge that folds in the 16th accepted bit since the last wipe. While `word_ready` is 0, `word_out` reads as zero.
- R6: Once `word_ready` is set, further accepted bits keep folding into the word as in R4, and `word_ready` stays 1 until a read.
- R7: If `rd_strobe` is 1 while `word_ready` is 1, `word_out` carries the complete word in that cycle. On the next edge the buffer and its bit count are cleared and `word_ready` drops.
- R8: If a read (as in R7) and an accepted bit fall in the same cycle, the read returns the word as it was before that bit. The bit becomes the first bit of the new word, so the new buffer equals that bit and its count is 1.
- R9: `rd_strobe` while `word_ready` is 0 has no effect on the buffer or its count.
- R10: After reset, `word_ready` is 0, `word_out` is zero, the buffer is empty and the pair phase expects a first sample.
- R11: A cycle with `raw_valid` at 0 consumes no sample and leaves the pair phase where it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| raw_valid | input | 1 | Sample strobe for the chain bits |
| raw_bits | input | NCHAIN | One sampled bit per noise chain |
| rd_strobe | input | 1 | Consumer read strobe; takes and wipes the word |
| word_ready | output | 1 | A complete word is available |
| word_out | output | WORD_W | Complete word, zero when not ready |

## Verification
Two operations can fall in the same clock cycle: the consumer's wipe and the folding of a newly accepted bit. The bench provokes this by asserting the read strobe on a fixed stride during an exhaustive sweep over sample pairs. At that stride, reads land both on the second sample of an unequal pair and on rejected or partial pairs. Each such read is judged twice against an arithmetic model. First, the word sampled before the edge must be the pre-update word. Second, after the edge, the following sixteen accepted bits must rebuild exactly the word that starts from the coincident bit alone.

// File: rtl/efc_pkg.sv
package efc_pkg;
   localparam int unsigned MAX_CHAINS = 8;

   function automatic logic [63:0] rotl_one(input logic [63:0] v, input int unsigned w);
      logic [63:0] r;
      r = '0;
      for (int unsigned i = 0; i < 64; i++) begin
         if (i < w) r[(i + 1) % w] = v[i];
      end
      return r;
   endfunction
endpackage

// File: rtl/chain_combiner.sv
module chain_combiner #(
   parameter int unsigned NCHAIN = 4
) (
   input  logic [NCHAIN-1:0] chains,
   output logic              mixed
);
   generate
      if (NCHAIN == 1) begin : g_single
         assign mixed = chains[0];
      end else begin : g_multi
         assign mixed = ^chains;
      end
   endgenerate
endmodule

// File: rtl/pair_extractor.sv
module pair_extractor (
   input  logic clk,
   input  logic rst_n,
   input  logic smp_valid,
   input  logic smp_bit,
   output logic acc_valid,
   output logic acc_bit
);
   logic have_first;
   logic first_bit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         have_first <= 1'b0;
         first_bit  <= 1'b0;
      end else if (smp_valid) begin
         have_first <= ~have_first;
         if (!have_first) first_bit <= smp_bit;
      end
   end

   assign acc_valid = smp_valid & have_first & (first_bit ^ smp_bit);
   assign acc_bit   = first_bit;
endmodule

// File: rtl/fold_buffer.sv
module fold_buffer #(
   parameter int unsigned WORD_W = 16,
   localparam int unsigned CNT_W = $clog2(WORD_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic              acc_bit,
   input  logic              rd_strobe,
   output logic              word_ready,
   output logic [WORD_W-1:0] word_out,
   output logic [CNT_W-1:0]  fill_cnt
);
   import efc_pkg::*;

   localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

   logic [WORD_W-1:0] acc_word;
   logic [WORD_W-1:0] folded;
   logic              take;

   assign word_ready = (fill_cnt == FULL);
   assign take       = rd_strobe & word_ready;
   assign folded     = rotl_one(64'(acc_word), WORD_W)[WORD_W-1:0] ^ {{(WORD_W-1){1'b0}}, acc_bit};
   assign word_out   = word_ready ? acc_word : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_word <= '0;
         fill_cnt <= '0;
      end else if (take) begin
         acc_word <= {{(WORD_W-1){1'b0}}, acc_valid & acc_bit};
         fill_cnt <= {{(CNT_W-1){1'b0}}, acc_valid};
      end else if (acc_valid) begin
         acc_word <= folded;
         if (fill_cnt != FULL) fill_cnt <= fill_cnt + 1'b1;
      end
   end
endmodule

// File: rtl/entropy_fold_conditioner.sv
module entropy_fold_conditioner #(
   parameter int unsigned NCHAIN = 4,
   parameter int unsigned WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              raw_valid,
   input  logic [NCHAIN-1:0] raw_bits,
   input  logic              rd_strobe,
   output logic              word_ready,
   output logic [WORD_W-1:0] word_out
);
   import efc_pkg::*;

   localparam int unsigned CNT_W = $clog2(WORD_W + 1);

   generate
      if (NCHAIN < 1 || NCHAIN > MAX_CHAINS) begin : g_bad_chains
         $error("entropy_fold_conditioner: NCHAIN out of range 1..8");
      end
      if (WORD_W < 2 || WORD_W > 64) begin : g_bad_width
         $error("entropy_fold_conditioner: WORD_W out of range 2..64");
      end
   endgenerate

   logic             smp_bit;
   logic             acc_valid;
   logic             acc_bit;
   logic [CNT_W-1:0] fill_cnt;

   chain_combiner #(.NCHAIN(NCHAIN)) u_mix (
      .chains(raw_bits),
      .mixed (smp_bit)
   );

   pair_extractor u_ext (
      .clk      (clk),
      .rst_n    (rst_n),
      .smp_valid(raw_valid),
      .smp_bit  (smp_bit),
      .acc_valid(acc_valid),
      .acc_bit  (acc_bit)
   );

   fold_buffer #(.WORD_W(WORD_W)) u_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .acc_valid (acc_valid),
      .acc_bit   (acc_bit),
      .rd_strobe (rd_strobe),
      .word_ready(word_ready),
      .word_out  (word_out),
      .fill_cnt  (fill_cnt)
   );
endmodule

// File: rtl/efc_checker.sv
module efc_checker #(
   parameter int unsigned WORD_W = 16,
   parameter int unsigned CNT_W  = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_strobe,
   input logic              word_ready,
   input logic [WORD_W-1:0] word_out,
   input logic              acc_valid,
   input logic [CNT_W-1:0]  fill_cnt
);
   assert_ready_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_strobe && word_ready |=> !word_ready);

   assert_wipe_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_strobe && word_ready && !acc_valid |=> fill_cnt == '0);

   assert_restart_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_strobe && word_ready && acc_valid |=> fill_cnt == CNT_W'(1));

   assert_ready_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
      word_ready && !rd_strobe |=> word_ready);

   assert_quiet_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid && !(rd_strobe && word_ready) |=> $stable(word_out));

   assert_rise_needs_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(word_ready) |-> $past(acc_valid));
endmodule

bind entropy_fold_conditioner efc_checker #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rd_strobe (rd_strobe),
   .word_ready(word_ready),
   .word_out  (word_out),
   .acc_valid (acc_valid),
   .fill_cnt  (fill_cnt)
);

// File: tb/entropy_fold_conditioner_test.sv
`timescale 1ns/100ps
module entropy_fold_conditioner_test;
   localparam int NCH = 4;
   localparam int W   = 16;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           raw_valid = 1'b0;
   logic [NCH-1:0] raw_bits = '0;
   logic           rd_strobe = 1'b0;
   logic           word_ready;
   logic [W-1:0]   word_out;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   // reference model state
   bit         m_ph = 1'b0;
   bit         m_fb = 1'b0;
   logic [W-1:0] m_buf = '0;
   int         m_cnt = 0;

   always #2.5 clk = ~clk;

   entropy_fold_conditioner #(.NCHAIN(NCH), .WORD_W(W)) uut (
      .clk(clk), .rst_n(rst_n), .raw_valid(raw_valid), .raw_bits(raw_bits),
      .rd_strobe(rd_strobe), .word_ready(word_ready), .word_out(word_out)
   );

   task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic step(input bit v, input logic [NCH-1:0] bits, input bit rd, input string tag);
      bit sb, acc, abit, take;
      @(negedge clk);
      raw_valid = v; raw_bits = bits; rd_strobe = rd;
      #1;
      take = rd && (m_cnt >= W);
      if (take) check({tag, " R7 read word"}, word_out, m_buf);
      sb = ^bits; acc = 1'b0; abit = 1'b0;
      if (v) begin
         if (!m_ph) begin m_ph = 1'b1; m_fb = sb; end
         else begin
            m_ph = 1'b0;
            if (m_fb != sb) begin acc = 1'b1; abit = m_fb; end
         end
      end
      if (take) begin
         m_buf = acc ? W'(abit) : '0;
         m_cnt = acc ? 1 : 0;
      end else if (acc) begin
         m_buf = {m_buf[W-2:0], m_buf[W-1]} ^ W'(abit);
         if (m_cnt < W) m_cnt++;
      end
      @(posedge clk);
      #1;
      check({tag, " ready"}, W'(word_ready), W'(m_cnt >= W));
      check({tag, " word"}, word_out, (m_cnt >= W) ? m_buf : '0);
   endtask

   initial begin
      #200000;
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #12;
      // R10: reset state
      check("R10 ready", W'(word_ready), '0);
      check("R10 word", word_out, '0);
      @(negedge clk); rst_n = 1'b1;

      // R9: read while not ready, then R1 single-chain pairs
      step(1'b0, '0, 1'b1, "R9");
      for (int c = 0; c < NCH; c++) begin
         step(1'b1, NCH'(1 << c), 1'b1, "R1 R9");
         step(1'b1, '0, 1'b0, "R1 R2");
      end
      // R1/R3: chains cancelling to zero versus one
      step(1'b1, 4'b0011, 1'b0, "R1 R3");
      step(1'b1, 4'b1111, 1'b0, "R1 R3");
      step(1'b1, 4'b0111, 1'b0, "R1 R2");
      step(1'b1, 4'b0110, 1'b0, "R1 R2");

      // Sweep A: every pair of chain patterns, no reads (R2 R3 R4 R5 R6)
      for (int a = 0; a < 16; a++)
         for (int b = 0; b < 16; b++) begin
            step(1'b1, 4'(a), 1'b0, "R2 R4 R5");
            step(1'b1, 4'(b), 1'b0, "R3 R6");
         end

      // Sweep B: reads on a stride of 5, landing on coincident accepts (R7 R8 R9)
      for (int a = 0; a < 16; a++)
         for (int b = 0; b < 16; b++) begin
            step(1'b1, 4'(a), ((a * 16 + b) % 5) == 0, "R7 R9");
            step(1'b1, 4'(b ^ 4'b1000), ((a * 16 + b) % 5) == 2, "R8");
         end

      // Sweep C: idle cycles between samples keep pair phase (R11)
      for (int a = 0; a < 16; a++)
         for (int b = 0; b < 16; b++) begin
            step(1'b1, 4'(a), 1'b0, "R11");
            step(1'b0, 4'(~a), 1'b0, "R11");
            step(1'b1, 4'(b), (b % 7) == 3, "R11 R7");
         end

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule